// File: doc/BRIEF.md
# Grouped GPIO interrupt controller

This block collects interrupt requests from up to 128 GPIO pins and two on-chip event sources. It sorts them into seven groups of 32 status bits and raises one interrupt line per group toward a downstream vectored interrupt controller. Each bit can be set to detect an edge or a level, and its polarity can be chosen. Every raw input first passes through a two-flop synchroniser. Status bits latch detected events. Software clears a status bit by writing 1 to it, and an enable register per group masks which status bits reach that group's interrupt line.

GPIO pins do not land on status bits in a simple linear order. The groups are filled in reverse order, starting from the highest group. Within a group, the four bytes of the pin index are swapped end for end, while the bit order inside each byte is kept. Several bits are hard-wired off. They read as zero in the status and enable registers, and writes to them have no effect. Group 0 carries a timer-match event and a USB cable event. Software reaches the block through a simple 32-bit register bus. Writes take effect on the clock edge, and reads are combinational.

Top module: `grpirq_ctrl`

## Requirements
- R1: After reset, every polarity, status, enable and type register reads 0 and all seven `ext_irq` outputs are 0.
- R2: The register at byte address 0x80+4g holds polarity, 0xA0+4g holds status, 0xC0+4g holds enable and 0xE0+4g holds type, for group g = 0..6. Polarity and type read back exactly what was written. Addresses whose group field (address bits 4:2) is 7 read 0, and writes to them change nothing.
- R3: With type bit 0 (edge), a status bit is set by a rising input when its polarity bit is 1 and by a falling input when it is 0. An edge of the opposite direction leaves the bit unchanged. A set bit stays set until it is cleared.
- R4: With type bit 1 (level), a status bit is set whenever the synchronised input equals its polarity bit (1 = high, 0 = low). A write-1 clear made while the level is still asserted leaves the bit set. Once the level goes away, the bit stays set until it is cleared.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R6: Output `ext_irq[6-g]` is 1 exactly when the bitwise AND of group g's status and enable registers is non-zero.
- R7: GPIO pin n drives group 6-(n>>5), bit (24-(n&24))|(n&7). For example, pin 0 drives group 6 bit 24, pin 8 drives group 6 bit 16 and pin 123 drives group 3 bit 3.
- R8: The following bits are disabled: group 3 bits 4..7 (pins 124..127), every bit of groups 1 and 2, and every bit of group 0 except bits 0 and 2. A disabled bit reads 0 in the enable and status registers, and writing to it has no effect.
- R9: `timer_evt` drives group 0 bit 0 and `usb_evt` drives group 0 bit 2.
- R10: Take an input change presented before clock edge 1. The status bit it sets is still 0 after edge 2 and reads 1 after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 128 | Raw GPIO pin levels, asynchronous |
| timer_evt | input | 1 | Timer match event, group 0 bit 0 |
| usb_evt | input | 1 | USB cable event, group 0 bit 2 |
| ext_irq | output | 7 | Group interrupt lines, `ext_irq[k]` served by group 6-k |

## Verification
A corrupted status or previous-sample flop shows up at the ports in one of two ways. Either a status read returns a stray or missing bit, or a group line in `ext_irq` rises or stays low, no later than the clock edge after the fault. A synchroniser stage that is lost or added shifts every status update by one edge, so the bench times a single transition edge by edge. A wrong bit permutation or a wrong disable mask sets the wrong bit, or leaves a dead bit alive. This is visible on the first status or enable read of the affected group after the pin moves. Random pin flips and register writes are compared after every step against a model of all 28 registers and the seven lines.

// File: rtl/grpirq_pkg.sv
// Package: shared constants, register bank codes and the fixed
// pin-to-status-bit permutation with its per-group disable masks.
// Assumes 32-bit groups and a byte-addressed bus with a 4-byte stride.
package grpirq_pkg;

    localparam int WORD_W = 32;
    localparam int BUS_AW = 8;

    // Register bank selected by address bits 7:5.
    typedef enum logic [2:0] {
        BANK_POL  = 3'd4,
        BANK_STAT = 3'd5,
        BANK_EN   = 3'd6,
        BANK_TYPE = 3'd7
    } bank_e;

    // Bits that can ever be set or enabled in each group.
    function automatic logic [WORD_W-1:0] live_mask(input int grp);
        case (grp)
            0:       return 32'h0000_0005;
            1, 2:    return '0;
            3:       return 32'hFFFF_FF0F;
            default: return '1;
        endcase
    endfunction

    // Group reached by a GPIO pin; pins fill groups from the top down.
    function automatic int pin_group(input int pin, input int top_grp);
        return top_grp - (pin >> 5);
    endfunction

    // Bit inside the group: byte order reversed, bits within a byte kept.
    function automatic int pin_slot(input int pin);
        return (24 - (pin & 24)) | (pin & 7);
    endfunction

endpackage

// File: rtl/grpirq_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each input bit is independent (no bus coherency needed).
module grpirq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    // Shift raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/grpirq_group.sv
// One interrupt group: synchronises its sources and detects edges or
// levels per bit. It holds the polarity, type, enable and status
// registers, and raises one interrupt when an enabled status bit is set.
// Assumes write strobes are already decoded for this group. Bits
// outside LIVE never set and never enable.
module grpirq_group #(
    parameter int               GRP_W       = 32,
    parameter int               SYNC_STAGES = 2,
    parameter logic [GRP_W-1:0] LIVE        = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] src_i,
    input  logic             wr_pol_i,
    input  logic             wr_stat_i,
    input  logic             wr_en_i,
    input  logic             wr_type_i,
    input  logic [GRP_W-1:0] wdata_i,
    output logic [GRP_W-1:0] pol_o,
    output logic [GRP_W-1:0] stat_o,
    output logic [GRP_W-1:0] en_o,
    output logic [GRP_W-1:0] type_o,
    output logic             irq_o
);

    logic [GRP_W-1:0] smp, prev_q;
    logic [GRP_W-1:0] pol_q, stat_q, en_q, type_q;
    logic [GRP_W-1:0] edge_hit, lvl_hit, hit, clr;

    grpirq_sync #(.W(GRP_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (src_i),
        .sync_o (smp)
    );

    // Remember the last synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= smp;
    end

    // Per-bit event: polarity-qualified edge or level, type-selected.
    always_comb begin
        edge_hit = (pol_q & smp & ~prev_q) | (~pol_q & ~smp & prev_q);
        lvl_hit  = ~(pol_q ^ smp);
        hit      = ((type_q & lvl_hit) | (~type_q & edge_hit)) & LIVE;
        clr      = wr_stat_i ? wdata_i : '0;
    end

    // Configuration registers: polarity and type take any value, enable is masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q  <= '0;
            type_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_pol_i)  pol_q  <= wdata_i;
            if (wr_type_i) type_q <= wdata_i;
            if (wr_en_i)   en_q   <= wdata_i & LIVE;
        end
    end

    // Status: write-1 clear, and a new event in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= ((stat_q & ~clr) | hit) & LIVE;
    end

    assign irq_o  = |(stat_q & en_q);
    assign pol_o  = pol_q;
    assign stat_o = stat_q;
    assign en_o   = en_q;
    assign type_o = type_q;

    // A cleared bit with no event in the same cycle reads 0 afterwards.
    assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stat_i |=> ((stat_q & $past(wdata_i & ~hit)) == '0));

    // Without a clear, a set status bit never drops.
    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // An asserted level source holds its bit set, even through a clear.
    assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_q & $past(hit & type_q)) == $past(hit & type_q)));

    // The group line can only rise after a status or enable change.
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (!$stable(stat_q) || !$stable(en_q)));

endmodule

// File: rtl/grpirq_regif.sv
// Register bus decode: turns an address and write strobe into
// per-group, per-bank write strobes. It also selects the read data.
// Assumes the bank is in address bits 7:5 and the group in bits 4:2.
// Group code values at or above NUM_GRP are unmapped.
module grpirq_regif
    import grpirq_pkg::*;
#(
    parameter int NUM_GRP = 7,
    parameter int GRP_W   = 32
) (
    input  logic [BUS_AW-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [NUM_GRP-1:0][GRP_W-1:0] pol_all,
    input  logic [NUM_GRP-1:0][GRP_W-1:0] stat_all,
    input  logic [NUM_GRP-1:0][GRP_W-1:0] en_all,
    input  logic [NUM_GRP-1:0][GRP_W-1:0] type_all,
    output logic [NUM_GRP-1:0]            wr_pol,
    output logic [NUM_GRP-1:0]            wr_stat,
    output logic [NUM_GRP-1:0]            wr_en,
    output logic [NUM_GRP-1:0]            wr_type,
    output logic [GRP_W-1:0]              rdata
);

    localparam int GSEL_W = $clog2(NUM_GRP);

    logic [2:0]        bank;
    logic [GSEL_W-1:0] gsel;
    logic              gvalid;
    logic              unused_low_addr;

    assign bank            = bus_addr[7:5];
    assign gsel            = bus_addr[2 +: GSEL_W];
    assign gvalid          = int'(gsel) < NUM_GRP;
    assign unused_low_addr = ^bus_addr[1:0];

    // Decode the write strobe and the read mux from bank and group fields.
    always_comb begin
        wr_pol  = '0;
        wr_stat = '0;
        wr_en   = '0;
        wr_type = '0;
        rdata   = '0;
        if (gvalid) begin
            case (bank)
                BANK_POL:  begin wr_pol[gsel]  = bus_we; rdata = pol_all[gsel];  end
                BANK_STAT: begin wr_stat[gsel] = bus_we; rdata = stat_all[gsel]; end
                BANK_EN:   begin wr_en[gsel]   = bus_we; rdata = en_all[gsel];   end
                BANK_TYPE: begin wr_type[gsel] = bus_we; rdata = type_all[gsel]; end
                default:   rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/grpirq_ctrl.sv
// Top: routes GPIO pins through the fixed permutation into the groups,
// adds the two on-chip event sources to group 0, instantiates one
// group slice per group and orders the group lines for the downstream
// controller. Assumes NUM_PINS <= 32*4, so pins fill the top four
// groups only.
module grpirq_ctrl
    import grpirq_pkg::*;
#(
    parameter int NUM_GRP     = 7,
    parameter int GRP_W       = WORD_W,
    parameter int NUM_PINS    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [GRP_W-1:0]    bus_wdata,
    output logic [GRP_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                timer_evt,
    input  logic                usb_evt,
    output logic [NUM_GRP-1:0]  ext_irq
);

    localparam int GSEL_W = $clog2(NUM_GRP);
    localparam int BSEL_W = $clog2(GRP_W);
    localparam int TOP_G  = NUM_GRP - 1;

    logic [NUM_GRP-1:0][GRP_W-1:0] grp_src;
    logic [NUM_GRP-1:0][GRP_W-1:0] pol_all, stat_all, en_all, type_all;
    logic [NUM_GRP-1:0]            wr_pol, wr_stat, wr_en, wr_type;
    logic [NUM_GRP-1:0]            grp_irq;

    // Scatter pins into group bit positions; place the on-chip events.
    always_comb begin
        grp_src = '0;
        for (int n = 0; n < NUM_PINS; n++) begin
            grp_src[GSEL_W'(pin_group(n, TOP_G))][BSEL_W'(pin_slot(n))] = pin_in[n];
        end
        grp_src[0][0] = timer_evt;
        grp_src[0][2] = usb_evt;
    end

    grpirq_regif #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_regif (
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .pol_all  (pol_all),
        .stat_all (stat_all),
        .en_all   (en_all),
        .type_all (type_all),
        .wr_pol   (wr_pol),
        .wr_stat  (wr_stat),
        .wr_en    (wr_en),
        .wr_type  (wr_type),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        grpirq_group #(
            .GRP_W       (GRP_W),
            .SYNC_STAGES (SYNC_STAGES),
            .LIVE        (GRP_W'(live_mask(g)))
        ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (grp_src[g]),
            .wr_pol_i  (wr_pol[g]),
            .wr_stat_i (wr_stat[g]),
            .wr_en_i   (wr_en[g]),
            .wr_type_i (wr_type[g]),
            .wdata_i   (bus_wdata),
            .pol_o     (pol_all[g]),
            .stat_o    (stat_all[g]),
            .en_o      (en_all[g]),
            .type_o    (type_all[g]),
            .irq_o     (grp_irq[g])
        );
        // Group g is served by external line TOP_G - g.
        assign ext_irq[TOP_G-g] = grp_irq[g];
    end

    // Disabled bits never appear on the bus in the status or enable banks.
    assert_dead_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (((bus_addr[7:5] == BANK_STAT) || (bus_addr[7:5] == BANK_EN))
          && (int'(bus_addr[4:2]) < NUM_GRP))
        |-> ((bus_rdata & ~GRP_W'(live_mask(int'(bus_addr[4:2])))) == '0));

endmodule

// File: tb/tb_grpirq_ctrl.sv
`timescale 1ns/1ps
module tb_grpirq_ctrl;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] pins = '0;
    logic         tmr = 1'b0;
    logic         usb = 1'b0;
    logic [6:0]   ext_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_pol [7];
    logic [31:0] m_stat[7];
    logic [31:0] m_en  [7];
    logic [31:0] m_type[7];
    logic [31:0] m_src [7];

    always #4 clk = ~clk;

    grpirq_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pins),
        .timer_evt (tmr),
        .usb_evt   (usb),
        .ext_irq   (ext_irq)
    );

    // Live bits per group as stated in R8.
    function automatic logic [31:0] exp_mask(input int g);
        if (g == 0) return 32'h5;
        if (g == 1 || g == 2) return 32'h0;
        if (g == 3) return 32'hFFFF_FF0F;
        return 32'hFFFF_FFFF;
    endfunction

    // Line k is served by group 6-k (R6).
    function automatic logic [6:0] exp_irq();
        logic [6:0] r = '0;
        for (int g = 0; g < 7; g++) r[6-g] = |(m_stat[g] & m_en[g]);
        return r;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Level sources (R4) keep their status set.
    task automatic mdl_level();
        for (int g = 0; g < 7; g++)
            m_stat[g] |= m_type[g] & ~(m_pol[g] ^ m_src[g]) & exp_mask(g);
    endtask

    task automatic mdl_wr(input logic [7:0] a, input logic [31:0] d);
        int g = int'(a[4:2]);
        if (g < 7) begin
            case (a[7:5])
                3'd4: m_pol[g] = d;
                3'd5: m_stat[g] &= ~d;
                3'd6: m_en[g] = d & exp_mask(g);
                3'd7: m_type[g] = d;
                default: ;
            endcase
        end
        mdl_level();
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        @(negedge clk);
        mdl_wr(a, d);
    endtask

    // Pin permutation (R7), group 0 event sources (R9), edge detection (R3).
    task automatic mdl_inputs();
        logic [31:0] nsrc[7];
        logic [31:0] edges;
        for (int g = 0; g < 7; g++) nsrc[g] = '0;
        for (int n = 0; n < 128; n++) nsrc[6 - n/32][(24 - (n & 24)) | (n % 8)] = pins[n];
        nsrc[0][0] = tmr;
        nsrc[0][2] = usb;
        for (int g = 0; g < 7; g++) begin
            edges = (m_pol[g] & ~m_src[g] & nsrc[g]) | (~m_pol[g] & m_src[g] & ~nsrc[g]);
            m_stat[g] |= ~m_type[g] & edges & exp_mask(g);
            m_src[g] = nsrc[g];
        end
        mdl_level();
    endtask

    task automatic drive(input logic [127:0] p, input logic t, input logic u);
        @(negedge clk);
        pins = p; tmr = t; usb = u;
        repeat (4) @(negedge clk);
        mdl_inputs();
    endtask

    task automatic check_all(input string ctx);
        logic [31:0] d;
        for (int g = 0; g < 7; g++) begin
            rd(8'(8'h80 + 4*g), d); chk($sformatf("R2 pol g%0d %s", g, ctx), d, m_pol[g]);
            rd(8'(8'hA0 + 4*g), d); chk($sformatf("R3 status g%0d %s", g, ctx), d, m_stat[g]);
            rd(8'(8'hC0 + 4*g), d); chk($sformatf("R8 enable g%0d %s", g, ctx), d, m_en[g]);
            rd(8'(8'hE0 + 4*g), d); chk($sformatf("R2 type g%0d %s", g, ctx), d, m_type[g]);
        end
        @(negedge clk);
        chk($sformatf("R6 ext_irq %s", ctx), 32'(ext_irq), 32'(exp_irq()));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0]  d;
        logic [127:0] p;
        void'($urandom(32'd51723));
        for (int g = 0; g < 7; g++) begin
            m_pol[g] = '0; m_stat[g] = '0; m_en[g] = '0; m_type[g] = '0; m_src[g] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check_all("R1 reset");

        // R2: round trip on group 4, then the unmapped group code 7
        wr(8'h90, 32'hA5C3_0F96);
        wr(8'hF0, 32'h0000_0000);
        rd(8'h90, d); chk("R2 pol readback", d, 32'hA5C3_0F96);
        wr(8'h9C, 32'hFFFF_FFFF);
        rd(8'h9C, d); chk("R2 unmapped group reads 0", d, 32'h0);
        wr(8'h90, 32'h0);
        wr(8'hB0, 32'hFFFF_FFFF);

        // R8: enable everything; disabled bits must read 0
        for (int g = 0; g < 7; g++) wr(8'(8'hC0 + 4*g), 32'hFFFF_FFFF);
        rd(8'hC0, d); chk("R8 group0 enable", d, 32'h5);
        rd(8'hC4, d); chk("R8 group1 enable", d, 32'h0);
        rd(8'hCC, d); chk("R8 group3 enable", d, 32'hFFFF_FF0F);
        check_all("R8 enables");

        // R10 latency and R7 pin 0 -> group 6 bit 24 (rising edge)
        wr(8'h98, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_addr = 8'hB8;
        pins[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); #1;
        chk("R10 status still clear after edge 2", 32'(bus_rdata[24]), 32'h0);
        @(negedge clk); #1;
        chk("R10 status set after edge 3", 32'(bus_rdata[24]), 32'h1);
        repeat (2) @(negedge clk);
        mdl_inputs();
        chk("R6 line 0 from group 6", 32'(ext_irq[0]), 32'h1);

        // R7 permutation and R8 dead pin 127
        wr(8'h8C, 32'hFFFF_FFFF);
        p = pins; p[8] = 1'b1; p[123] = 1'b1; p[127] = 1'b1;
        drive(p, 1'b0, 1'b0);
        rd(8'hB8, d); chk("R7 pin 8 -> g6 bit16", d & 32'h0001_0000, 32'h0001_0000);
        rd(8'hAC, d); chk("R7 pin 123 -> g3 bit3", d & 32'h08, 32'h08);
        chk("R8 pin 127 dead", d & 32'h80, 32'h0);

        // R5 write-1 clear
        wr(8'hB8, 32'h0);
        rd(8'hB8, d); chk("R5 write 0 keeps", d, 32'h0101_0000);
        wr(8'hB8, 32'h0100_0000);
        rd(8'hB8, d); chk("R5 write 1 clears", d, 32'h0001_0000);

        // R3 falling edge on pin 32 -> group 5 bit 24 (polarity 0)
        p = pins; p[32] = 1'b1;
        drive(p, 1'b0, 1'b0);
        rd(8'hB4, d); chk("R3 rise ignored when falling", d & 32'h0100_0000, 32'h0);
        p[32] = 1'b0;
        drive(p, 1'b0, 1'b0);
        rd(8'hB4, d); chk("R3 falling sets", d & 32'h0100_0000, 32'h0100_0000);

        // R4 level on pin 64 -> group 4 bit 24
        wr(8'hF0, 32'h0100_0000);
        wr(8'h90, 32'h0100_0000);
        p = pins; p[64] = 1'b1;
        drive(p, 1'b0, 1'b0);
        rd(8'hB0, d); chk("R4 level high sets", d & 32'h0100_0000, 32'h0100_0000);
        wr(8'hB0, 32'h0100_0000);
        rd(8'hB0, d); chk("R4 clear while asserted holds", d & 32'h0100_0000, 32'h0100_0000);
        p[64] = 1'b0;
        drive(p, 1'b0, 1'b0);
        rd(8'hB0, d); chk("R4 latched after release", d & 32'h0100_0000, 32'h0100_0000);
        wr(8'hB0, 32'h0100_0000);
        rd(8'hB0, d); chk("R4 cleared after release", d & 32'h0100_0000, 32'h0);
        wr(8'h90, 32'h0);
        rd(8'hB0, d); chk("R4 level low sets", d & 32'h0100_0000, 32'h0100_0000);
        wr(8'hF0, 32'h0);
        wr(8'hB0, 32'hFFFF_FFFF);

        // R9 group 0 event sources
        wr(8'h80, 32'hFFFF_FFFF);
        drive(pins, 1'b1, 1'b0);
        rd(8'hA0, d); chk("R9 timer -> g0 bit0", d, 32'h1);
        @(negedge clk); chk("R6 line 6 from group 0", 32'(ext_irq[6]), 32'h1);
        drive(pins, 1'b1, 1'b1);
        rd(8'hA0, d); chk("R9 usb -> g0 bit2", d, 32'h5);
        check_all("directed end");

        // Random mix of pin changes, configuration writes and clears
        for (int it = 0; it < 400; it++) begin
            case ($urandom % 4)
                0, 1: begin
                    p = pins;
                    for (int k = 0; k < 1 + int'($urandom % 8); k++) p[$urandom % 128] ^= 1'b1;
                    drive(p, 1'($urandom), 1'($urandom));
                end
                2: wr({3'(4 + $urandom % 4), 3'($urandom), 2'b00}, $urandom);
                default: wr({3'd5, 3'($urandom), 2'b00}, $urandom);
            endcase
            check_all($sformatf("random %0d", it));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule